// File: doc/BRIEF.md
# ARINC 429 Transmit Serializer

This block turns 31-bit data words into 32-bit ARINC 429 frames and drives them as return-to-zero pulses on two complementary line rails. An external word queue supplies the head word together with an empty indication; the serializer pops a word, appends a parity bit whose sense is chosen by a control input, and sends the 32 bits least significant first. Each bit has a data half and a null half of equal length, and a fixed gap of null separates consecutive frames.

A clock divider sets the bit pace: high speed uses the system clock directly, low speed slows every phase by a fixed ratio. Speed and parity sense are captured when a word is taken, so changes on those inputs apply from the next word onwards. A loopback path mirrors the line rails onto two receiver-side pairs when self-test is selected: the first pair carries the line signal as sent, the second the complemented signal (rails exchanged). An active-low master reset stops any frame at once and clears the sequencer; the control inputs are held outside the block and therefore survive reset.

Top module: `a429_tx_serializer`

## Requirements
- R1: After reset both line rails and all four loopback rails are low, and `tx_ready` is high while the queue is empty.
- R2: Frame bits 0 to 30 carry queue word bits 0 to 30 in that order and bit 31 carries parity; for each bit, `line_a` is high during the data half when the bit is 1, `line_b` is high during the data half when it is 0, and both are low during the null half. The first data half starts on the clock after the word is popped.
- R3: With `par_even` low the frame has an odd number of ones; with `par_even` high it has an even number; the sense is taken when the word is popped.
- R4: With `low_speed` low each half-bit lasts 5 clocks and the word gap 40 clocks; with `low_speed` high each half-bit lasts 40 clocks and the gap 320 clocks.
- R5: While `tx_en` is high and the queue holds words, frames follow one another separated by exactly one word gap, and the next word is popped in the last gap clock.
- R6: A change of `low_speed` during a frame does not alter that frame or its gap; the new speed applies to the next word popped.
- R7: While `tx_en` is low no word is popped and the rails stay low, even with words queued.
- R8: With `self_test_n` low, `rx1_a`/`rx1_b` equal `line_a`/`line_b` and `rx2_a`/`rx2_b` equal `line_b`/`line_a`; with it high all loopback rails are low. The line rails are driven in both cases.
- R9: Master reset low drives both line rails low without waiting for a clock; after release, frames use the control input values that were present before reset.
- R10: Dropping `tx_en` during a frame lets that frame and its gap complete, then no further word is popped.
- R11: `tx_ready` is low from the pop of a word until the gap after the last frame has ended, and high once the sequencer is idle with an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset, asynchronous |
| tx_en | input | 1 | Transmit enable |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| low_speed | input | 1 | Speed select: 0 high, 1 low |
| self_test_n | input | 1 | Active-low loopback enable |
| fifo_empty | input | 1 | Word queue holds no word |
| fifo_word | input | 31 | Head word of the queue |
| fifo_pop | output | 1 | Takes the head word this clock |
| tx_ready | output | 1 | Idle with empty queue |
| line_a | output | 1 | Line rail high for a one |
| line_b | output | 1 | Line rail high for a zero |
| rx1_a | output | 1 | Loopback to receiver 1, one rail |
| rx1_b | output | 1 | Loopback to receiver 1, zero rail |
| rx2_a | output | 1 | Loopback to receiver 2, one rail |
| rx2_b | output | 1 | Loopback to receiver 2, zero rail |

## Verification
The bench builds the block with its default parameters: 5-tick half-bits, a 40-tick gap, a ratio of 1 for high speed and 8 for low speed. These values make both speeds cheap enough to run several complete frames each, so every bit index up to the parity position, the gap-to-load hand-off, a speed change across a word boundary and the idle return are all compared clock by clock against a frame built in the bench from the word and the parity sense.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_NULL = 2'd2,
        ST_GAP  = 2'd3
    } tx_state_e;

endpackage

// File: rtl/a429_tx_divider.sv
module a429_tx_divider #(
    parameter int HS_RATIO = 1,
    parameter int LS_RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic low_speed,
    output logic tick
);
    localparam int MAX_RATIO = (LS_RATIO > HS_RATIO) ? LS_RATIO : HS_RATIO;
    localparam int CW        = $clog2(MAX_RATIO + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = low_speed ? CW'(LS_RATIO - 1) : CW'(HS_RATIO - 1);
        tick  = (div_q.cnt == limit);
        div_d = div_q;
        if (restart || tick) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.cnt <= CW'(MAX_RATIO - 1)) else $error("divider count out of range"); // R4

endmodule

// File: rtl/a429_tx_parity.sv
module a429_tx_parity #(
    parameter int DATA_W = 31
) (
    input  logic [DATA_W-1:0] data,
    input  logic              even_sel,
    output logic              pbit
);
    logic ones_odd;

    always_comb begin
        ones_odd = ^data;
        // odd sense: add a one when the data count is even
        pbit = (~ones_odd) ^ even_sel;
    end

endmodule

// File: rtl/a429_tx_loopback.sv
module a429_tx_loopback (
    input  logic self_test_n,
    input  logic line_a,
    input  logic line_b,
    output logic rx1_a,
    output logic rx1_b,
    output logic rx2_a,
    output logic rx2_b
);
    logic active;

    always_comb begin
        active = ~self_test_n;
        rx1_a  = active & line_a;
        rx1_b  = active & line_b;
        // complemented signal: rails exchanged
        rx2_a  = active & line_b;
        rx2_b  = active & line_a;
    end

endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
    import a429_tx_pkg::*;
#(
    parameter int DATA_W     = 31,
    parameter int HALF_TICKS = 5,
    parameter int GAP_TICKS  = 40,
    parameter int HS_RATIO   = 1,
    parameter int LS_RATIO   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              par_even,
    input  logic              low_speed,
    input  logic              self_test_n,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_word,
    output logic              fifo_pop,
    output logic              tx_ready,
    output logic              line_a,
    output logic              line_b,
    output logic              rx1_a,
    output logic              rx1_b,
    output logic              rx2_a,
    output logic              rx2_b
);
    localparam int FRAME_W = DATA_W + 1;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int PH_MAX  = (GAP_TICKS > HALF_TICKS) ? GAP_TICKS : HALF_TICKS;
    localparam int PH_W    = $clog2(PH_MAX + 1);

    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] sreg;
        logic [BIT_W-1:0]   bitn;
        logic [PH_W-1:0]    ph;
        logic               spd;
    } seq_t;

    seq_t seq_d, seq_q;
    logic tick;
    logic restart;
    logic pbit;
    logic can_load;
    logic half_end;
    logic gap_end;

    a429_tx_parity #(.DATA_W(DATA_W)) i_parity (
        .data     (fifo_word),
        .even_sel (par_even),
        .pbit     (pbit)
    );

    a429_tx_divider #(.HS_RATIO(HS_RATIO), .LS_RATIO(LS_RATIO)) i_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .low_speed (seq_q.spd),
        .tick      (tick)
    );

    always_comb begin
        seq_d    = seq_q;
        fifo_pop = 1'b0;
        restart  = 1'b0;
        can_load = tx_en && !fifo_empty;
        half_end = tick && (seq_q.ph == PH_W'(HALF_TICKS - 1));
        gap_end  = tick && (seq_q.ph == PH_W'(GAP_TICKS - 1));

        unique case (seq_q.st)
            ST_IDLE: begin
                if (can_load) begin
                    fifo_pop   = 1'b1;
                    restart    = 1'b1;
                    seq_d.st   = ST_DATA;
                    seq_d.sreg = {pbit, fifo_word};
                    seq_d.bitn = '0;
                    seq_d.ph   = '0;
                    seq_d.spd  = low_speed;
                end
            end
            ST_DATA: begin
                if (half_end) begin
                    seq_d.ph = '0;
                    seq_d.st = ST_NULL;
                end else if (tick) begin
                    seq_d.ph = seq_q.ph + 1'b1;
                end
            end
            ST_NULL: begin
                if (half_end) begin
                    seq_d.ph = '0;
                    if (seq_q.bitn == BIT_W'(FRAME_W - 1)) begin
                        seq_d.st   = ST_GAP;
                        seq_d.bitn = '0;
                    end else begin
                        seq_d.st   = ST_DATA;
                        seq_d.bitn = seq_q.bitn + 1'b1;
                        seq_d.sreg = {1'b0, seq_q.sreg[FRAME_W-1:1]};
                    end
                end else if (tick) begin
                    seq_d.ph = seq_q.ph + 1'b1;
                end
            end
            ST_GAP: begin
                if (gap_end) begin
                    seq_d.ph = '0;
                    if (can_load) begin
                        fifo_pop   = 1'b1;
                        restart    = 1'b1;
                        seq_d.st   = ST_DATA;
                        seq_d.sreg = {pbit, fifo_word};
                        seq_d.bitn = '0;
                        seq_d.spd  = low_speed;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end else if (tick) begin
                    seq_d.ph = seq_q.ph + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        line_a   = (seq_q.st == ST_DATA) &&  seq_q.sreg[0];
        line_b   = (seq_q.st == ST_DATA) && !seq_q.sreg[0];
        tx_ready = (seq_q.st == ST_IDLE) && fifo_empty;
    end

    a429_tx_loopback i_loopback (
        .self_test_n (self_test_n),
        .line_a      (line_a),
        .line_b      (line_b),
        .rx1_a       (rx1_a),
        .rx1_b       (rx1_b),
        .rx2_a       (rx2_a),
        .rx2_b       (rx2_b)
    );

    AST_POP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (tx_en && !fifo_empty)) else $error("pop without enable"); // R7

    AST_DATA_THEN_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_DATA) |=> (seq_q.st == ST_DATA || seq_q.st == ST_NULL))
        else $error("data half left wrongly"); // R2

    AST_GAP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_GAP) |=> (seq_q.st != ST_NULL)) else $error("gap left into null"); // R5

    AST_SPEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st != ST_IDLE) && !$past(fifo_pop)) |-> $stable(seq_q.spd))
        else $error("speed changed inside a frame"); // R6

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !(line_a || line_b)) else $error("ready while driving"); // R11

endmodule

// File: tb/test_a429_tx_serializer.sv
module test_a429_tx_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 5;
    localparam int GAP  = 40;
    localparam int HSR  = 1;
    localparam int LSR  = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_en, par_even, low_speed, self_test_n;
    logic        fifo_empty, fifo_pop, tx_ready;
    logic [30:0] fifo_word;
    logic        line_a, line_b, rx1_a, rx1_b, rx2_a, rx2_b;

    logic [30:0] qmem [8];
    logic [3:0]  rd_ptr;
    logic [3:0]  wr_ptr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    a429_tx_serializer i_a429_tx_serializer (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .par_even(par_even),
        .low_speed(low_speed), .self_test_n(self_test_n),
        .fifo_empty(fifo_empty), .fifo_word(fifo_word), .fifo_pop(fifo_pop),
        .tx_ready(tx_ready), .line_a(line_a), .line_b(line_b),
        .rx1_a(rx1_a), .rx1_b(rx1_b), .rx2_a(rx2_a), .rx2_b(rx2_b)
    );

    assign fifo_empty = (rd_ptr == wr_ptr);
    assign fifo_word  = qmem[rd_ptr[2:0]];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_ptr <= '0;
        else if (fifo_pop) rd_ptr <= rd_ptr + 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [30:0] w);
        qmem[wr_ptr[2:0]] = w;
        wr_ptr = wr_ptr + 1'b1;
    endtask

    function automatic logic [31:0] frame_of(input logic [30:0] w, input bit even);
        logic p;
        p = ($countones(w) % 2 == 0) ? 1'b1 : 1'b0;
        if (even) p = ~p;
        return {p, w};
    endfunction

    function automatic bit rails_ok(input logic ea, input logic eb);
        bit ok;
        ok = (line_a == ea) && (line_b == eb);
        if (self_test_n)
            ok = ok && !rx1_a && !rx1_b && !rx2_a && !rx2_b;
        else
            ok = ok && rx1_a == ea && rx1_b == eb && rx2_a == eb && rx2_b == ea;
        return ok;
    endfunction

    // Samples one frame, starting at the negedge before its first data clock.
    // poke_kind 1: raise low_speed at poke_bit; 2: drop tx_en at poke_bit.
    task automatic expect_word(input logic [30:0] w, input bit even, input int r,
                               input int poke_bit, input int poke_kind, input string req);
        logic [31:0] f;
        int errs;
        f = frame_of(w, even);
        errs = 0;
        for (int b = 0; b < 32; b++) begin
            if (b == poke_bit && poke_kind == 1) low_speed = 1'b1;
            if (b == poke_bit && poke_kind == 2) tx_en = 1'b0;
            for (int s = 0; s < HALF*r; s++) begin
                @(negedge clk);
                if (!rails_ok(f[b], ~f[b]) || tx_ready) errs++;
            end
            for (int s = 0; s < HALF*r; s++) begin
                @(negedge clk);
                if (!rails_ok(1'b0, 1'b0) || tx_ready) errs++;
            end
        end
        check(errs == 0, req, errs, 0);
    endtask

    task automatic expect_gap(input int r, input string req);
        int errs;
        errs = 0;
        for (int s = 0; s < GAP*r; s++) begin
            @(negedge clk);
            if (!rails_ok(1'b0, 1'b0) || tx_ready) errs++;
        end
        check(errs == 0, req, errs, 0);
    endtask

    task automatic expect_idle(input int cycles, input bit ready_exp, input string req);
        int errs;
        errs = 0;
        for (int s = 0; s < cycles; s++) begin
            @(negedge clk);
            if (!rails_ok(1'b0, 1'b0) || tx_ready != ready_exp) errs++;
        end
        check(errs == 0, req, errs, 0);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(!line_a && !line_b && !rx1_a && !rx1_b && !rx2_a && !rx2_b, "R1 rails",
              {line_a, line_b, rx1_a, rx1_b, rx2_a, rx2_b}, 0);
        check(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
    endtask

    task automatic t_single_hs_odd();
        push(31'h2A5C_3B1E);
        tx_en = 1'b1;
        expect_word(31'h2A5C_3B1E, 1'b0, HSR, -1, 0, "R2 R4 hs frame odd parity");
        expect_gap(HSR, "R4 hs gap");
        expect_idle(1, 1'b1, "R11 ready after gap");
        tx_en = 1'b0;
    endtask

    task automatic t_even_parity();
        par_even = 1'b1;
        push(31'h0000_0003);
        tx_en = 1'b1;
        expect_word(31'h0000_0003, 1'b1, HSR, -1, 0, "R3 even parity");
        expect_gap(HSR, "R3 gap");
        expect_idle(1, 1'b1, "R3 idle");
        tx_en = 1'b0;
        par_even = 1'b0;
    endtask

    task automatic t_low_speed_loopback();
        low_speed   = 1'b1;
        self_test_n = 1'b0;
        push(31'h7FFF_FFFF);
        tx_en = 1'b1;
        expect_word(31'h7FFF_FFFF, 1'b0, LSR, -1, 0, "R4 R8 ls frame with loopback");
        expect_gap(LSR, "R4 ls gap");
        expect_idle(1, 1'b1, "R4 idle");
        tx_en = 1'b0;
        low_speed   = 1'b0;
        self_test_n = 1'b1;
    endtask

    task automatic t_back_to_back();
        push(31'h1234_5678);
        push(31'h0000_0000);
        push(31'h5555_5555);
        tx_en = 1'b1;
        expect_word(31'h1234_5678, 1'b0, HSR, -1, 0, "R5 first of three");
        expect_gap(HSR, "R5 gap 1");
        expect_word(31'h0000_0000, 1'b0, HSR, -1, 0, "R5 second of three");
        expect_gap(HSR, "R5 gap 2");
        expect_word(31'h5555_5555, 1'b0, HSR, -1, 0, "R5 third of three");
        expect_gap(HSR, "R5 gap 3");
        expect_idle(2, 1'b1, "R11 ready after burst");
        tx_en = 1'b0;
    endtask

    task automatic t_speed_change();
        push(31'h0F0F_0F0F);
        push(31'h7000_0001);
        tx_en = 1'b1;
        expect_word(31'h0F0F_0F0F, 1'b0, HSR, 10, 1, "R6 frame kept at hs");
        expect_gap(HSR, "R6 gap kept at hs");
        expect_word(31'h7000_0001, 1'b0, LSR, -1, 0, "R6 next frame at ls");
        expect_gap(LSR, "R6 ls gap");
        expect_idle(1, 1'b1, "R6 idle");
        tx_en = 1'b0;
        low_speed = 1'b0;
    endtask

    task automatic t_enable_gating();
        push(31'h3333_CCCC);
        push(31'h4444_1111);
        expect_idle(60, 1'b0, "R7 no send while disabled");
        tx_en = 1'b1;
        expect_word(31'h3333_CCCC, 1'b0, HSR, 20, 2, "R10 frame finishes after enable drop");
        expect_gap(HSR, "R10 gap finishes");
        expect_idle(400, 1'b0, "R10 second word held");
        check(rd_ptr + 4'd1 == wr_ptr, "R10 one word left", int'(wr_ptr - rd_ptr), 1);
        tx_en = 1'b1;
        expect_word(31'h4444_1111, 1'b0, HSR, -1, 0, "R7 sent after enable");
        expect_gap(HSR, "R7 gap");
        expect_idle(1, 1'b1, "R7 idle");
        tx_en = 1'b0;
    endtask

    task automatic t_master_reset();
        par_even = 1'b1;
        push(31'h7FFF_0000);
        tx_en = 1'b1;
        repeat (23) @(negedge clk);
        rst_n = 1'b0;
        wr_ptr = '0;
        #1;
        check(!line_a && !line_b, "R9 rails drop at reset", {line_a, line_b}, 0);
        check(tx_ready == 1'b1, "R9 ready in reset", tx_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        expect_idle(20, 1'b1, "R9 idle after reset");
        push(31'h0000_0007);
        expect_word(31'h0000_0007, 1'b1, HSR, -1, 0, "R9 controls kept");
        expect_gap(HSR, "R9 gap");
        tx_en = 1'b0;
        par_even = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; tx_en = 1'b0; par_even = 1'b0; low_speed = 1'b0;
        self_test_n = 1'b1; wr_ptr = '0;
        for (int i = 0; i < 8; i++) qmem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_single_hs_odd();
        t_even_parity();
        t_low_speed_loopback();
        t_back_to_back();
        t_speed_change();
        t_enable_gating();
        t_master_reset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule